// File: doc/BRIEF.md
# Write-Only Bank Select Register

This block holds a small page number that lets several memory boards share one bus address range. Each board carries a strapped page number; the host selects one page at a time by writing to a single register address that every board decodes at once. The board whose strap matches the latched page is the active one. Its address decoder is gated by the bank-active output, so only that board answers memory cycles. A special write value switches the boards back to plain, non-banked operation.

The register is write-only. Read cycles to its address are never answered. Only the one board whose reply strap is fitted answers the register write. The other boards take the value silently, so the bus sees exactly one reply. The latched page also leaves the block on its own output, so the parity status register can show it and software can confirm the value that was written. A banking-enable strap turns the whole feature off. With banking off, the board behaves as an ordinary memory board and is always enabled.

Top module: `bank_select_reg`

## Requirements
- R1: A write cycle (`wrStb`=1, `rdStb`=0) to `BANK_ADDR` with `bankEn`=1 and `busInit`=0 loads `wrData[7:5]` into `latchedPage`. The new value appears after the next rising clock edge. The only exception is the restore value given in R5.
- R2: A cycle with `rdStb`=1 at `BANK_ADDR` changes no state and raises no `replyReq`. This holds even when `wrStb` is also high.
- R3: An accepted register write drives `replyReq` high for exactly the one cycle after the write, and only when `replyStrap`=1. With `replyStrap`=0 the value is still latched but no reply is given.
- R4: In banked mode with `bankEn`=1, `bankActive` is 1 when `latchedPage` equals `strapPage`, and 0 otherwise.
- R5: An accepted write of exactly 16'o000040 enters flat mode. In flat mode `bankActive` is 1 whatever the page, and `latchedPage` keeps its value. Any later accepted write of another value returns to banked mode with the new page.
- R6: `busInit`=1 clears `latchedPage` to 0, returns to banked mode and suppresses `replyReq` in the next cycle. It wins over a write in the same cycle.
- R7: With `bankEn`=0, `bankActive` is 1 and register writes change nothing and raise no reply.
- R8: Writes to any address other than `BANK_ADDR` are ignored.
- R9: After `rstN` is released, `latchedPage`=0, the block is in banked mode and `replyReq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busInit | input | 1 | Synchronous bus initialise |
| wrStb | input | 1 | Write cycle strobe, one cycle per bus write |
| rdStb | input | 1 | Read cycle strobe |
| wrAddr | input | 22 | Bus address of the cycle |
| wrData | input | 16 | Bus write data |
| strapPage | input | 3 | Page number strapped on this board |
| replyStrap | input | 1 | This board answers bank register writes |
| bankEn | input | 1 | Banking feature strapped on |
| bankActive | output | 1 | Enables this board's memory address decoder |
| replyReq | output | 1 | Reply request for an accepted register write |
| latchedPage | output | 3 | Currently latched page, for the parity register |

## Verification
A corrupted page register shows up at once on `latchedPage` and on `bankActive` in the cycle after the write that set it. The bench therefore reads both right after every write. A stuck flat-mode flag is only visible through `bankActive`. Pages that differ from the strap are used to separate it from a correct match. Reply faults appear in the single cycle after a write, and the bench also checks the cycle after that so a stretched pulse is caught.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  // Strobes from the control decoder to the page datapath
  typedef struct packed {
    logic clearAll;  // bus init: page to 0, banked mode
    logic loadPage;  // take new page, banked mode
    logic goFlat;    // restore value written: flat mode
  } bankStrobe_t;
endpackage

// File: rtl/bank_sel_ctrl.sv
module bank_sel_ctrl
  import bank_sel_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3,
  parameter int PAGE_LSB = 5,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 22'h3FE0A0,
  parameter logic [DATA_W-1:0] RESTORE_CODE = 16'o000040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busInit,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              replyStrap,
  input  logic              bankEn,
  output bankStrobe_t       strb,
  output logic [PAGE_W-1:0] pageIn,
  output logic              replyReq
);
  logic addrHit;
  logic regWrite;
  logic isRestore;
  logic replyQ;

  assign addrHit   = (wrAddr == BANK_ADDR);
  assign regWrite  = wrStb && !rdStb && bankEn && addrHit && !busInit;
  assign isRestore = (wrData == RESTORE_CODE);
  assign pageIn    = wrData[PAGE_LSB +: PAGE_W];

  always_comb begin
    strb          = '0;
    strb.clearAll = busInit;
    strb.loadPage = regWrite && !isRestore;
    strb.goFlat   = regWrite && isRestore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        replyQ <= 1'b0;
    else if (busInit) replyQ <= 1'b0;
    else              replyQ <= regWrite && replyStrap;
  end

  assign replyReq = replyQ;

  // R3: a reply only follows a cycle where this board held the strap
  p_reply_strap_r3: assert property (@(posedge clk) disable iff (!rstN)
    replyReq |-> $past(replyStrap));
  // R2: a read cycle never draws a reply
  p_read_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdStb) |-> !replyReq);
  // R8: other addresses never draw a reply
  p_other_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrAddr != BANK_ADDR) |-> !replyReq);
endmodule

// File: rtl/bank_sel_dp.sv
module bank_sel_dp
  import bank_sel_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic [PAGE_W-1:0] strapPage,
  input  logic              bankEn,
  output logic [PAGE_W-1:0] pageOut,
  output logic              bankActive
);
  logic [PAGE_W-1:0] pageQ;
  logic              flatQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      flatQ <= 1'b0;
    end else if (strb.clearAll) begin
      pageQ <= '0;
      flatQ <= 1'b0;
    end else if (strb.loadPage) begin
      pageQ <= pageIn;
      flatQ <= 1'b0;
    end else if (strb.goFlat) begin
      flatQ <= 1'b1;
    end
  end

  assign pageOut    = pageQ;
  assign bankActive = !bankEn || flatQ || (pageQ == strapPage);

  // R1: a load strobe puts the offered page in the register
  p_load_page_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadPage && !strb.clearAll) |-> (pageQ == $past(pageIn)));
  // R6: bus init leaves page 0 in banked mode
  p_init_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearAll) |-> (pageQ == '0 && !flatQ));
  // R5: flat-mode entry keeps the page
  p_flat_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.goFlat && !strb.clearAll) |-> (flatQ && $stable(pageQ)));
endmodule

// File: rtl/bank_select_reg.sv
module bank_select_reg
  import bank_sel_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3,
  parameter int PAGE_LSB = 5,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 22'h3FE0A0,
  parameter logic [DATA_W-1:0] RESTORE_CODE = 16'o000040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busInit,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PAGE_W-1:0] strapPage,
  input  logic              replyStrap,
  input  logic              bankEn,
  output logic              bankActive,
  output logic              replyReq,
  output logic [PAGE_W-1:0] latchedPage
);
  bankStrobe_t       strb;
  logic [PAGE_W-1:0] pageIn;

  bank_sel_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB),
    .BANK_ADDR(BANK_ADDR), .RESTORE_CODE(RESTORE_CODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busInit(busInit), .wrStb(wrStb), .rdStb(rdStb),
    .wrAddr(wrAddr), .wrData(wrData), .replyStrap(replyStrap), .bankEn(bankEn),
    .strb(strb), .pageIn(pageIn), .replyReq(replyReq)
  );

  bank_sel_dp #(.PAGE_W(PAGE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pageIn(pageIn),
    .strapPage(strapPage), .bankEn(bankEn),
    .pageOut(latchedPage), .bankActive(bankActive)
  );

  // R7: with banking off and no init, the page never moves
  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(!bankEn && !busInit) |-> $stable(latchedPage));
endmodule

// File: tb/test_bank_select_reg.sv
module test_bank_select_reg;
  localparam logic [21:0] BANK_ADDR = 22'h3FE0A0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busInit = 1'b0;
  logic        wrStb = 1'b0;
  logic        rdStb = 1'b0;
  logic [21:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  strapPage = 3'd3;
  logic        replyStrap = 1'b1;
  logic        bankEn = 1'b1;
  logic        bankActive;
  logic        replyReq;
  logic [2:0]  latchedPage;

  int nChecks = 0;
  int nFails = 0;

  bank_select_reg i_bank_select_reg (
    .clk(clk), .rstN(rstN), .busInit(busInit), .wrStb(wrStb), .rdStb(rdStb),
    .wrAddr(wrAddr), .wrData(wrData), .strapPage(strapPage),
    .replyStrap(replyStrap), .bankEn(bankEn), .bankActive(bankActive),
    .replyReq(replyReq), .latchedPage(latchedPage)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Outputs after a cycle: page, active, reply
  task automatic checkState(input string req, input int page, input int act, input int rep);
    check(req, "latchedPage", int'(latchedPage), page);
    check(req, "bankActive", int'(bankActive), act);
    check(req, "replyReq", int'(replyReq), rep);
  endtask

  // One bus cycle; returns at the negedge after the capturing edge
  task automatic busCycle(input logic w, input logic r, input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    wrStb = w; rdStb = r; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic replyGone(input string req);
    @(negedge clk);
    check(req, "reply one cycle only", int'(replyReq), 0);
  endtask

  task automatic testReset();
    checkState("R9", 0, 0, 0);
  endtask

  task automatic testLoadAndMatch();
    busCycle(1, 0, BANK_ADDR, 16'h0060);           // page 3
    checkState("R1", 3, 1, 1);
    replyGone("R3");
    busCycle(1, 0, BANK_ADDR, 16'hFFBF);           // bits 7:5 = 101
    checkState("R4", 5, 0, 1);
    replyGone("R3");
  endtask

  task automatic testRestore();
    busCycle(1, 0, BANK_ADDR, 16'o000040);
    checkState("R5", 5, 1, 1);
    replyGone("R5");
    busCycle(1, 0, BANK_ADDR, 16'h8020);           // not the restore code
    checkState("R5", 1, 0, 1);
    busCycle(1, 0, BANK_ADDR, 16'o000040);
    busCycle(1, 0, BANK_ADDR, 16'h0000);
    checkState("R5", 0, 0, 1);
  endtask

  task automatic testNoStrap();
    replyStrap = 1'b0;
    busCycle(1, 0, BANK_ADDR, 16'h0060);
    checkState("R3", 3, 1, 0);
    replyStrap = 1'b1;
  endtask

  task automatic testReads();
    busCycle(0, 1, BANK_ADDR, 16'h00C0);
    checkState("R2", 3, 1, 0);
    busCycle(1, 1, BANK_ADDR, 16'h00C0);
    checkState("R2", 3, 1, 0);
  endtask

  task automatic testOtherAddr();
    busCycle(1, 0, BANK_ADDR ^ 22'h000002, 16'h00C0);
    checkState("R8", 3, 1, 0);
    busCycle(1, 0, BANK_ADDR ^ 22'h200000, 16'h0000);
    checkState("R8", 3, 1, 0);
  endtask

  task automatic testDisabled();
    busCycle(1, 0, BANK_ADDR, 16'h00C0);           // page 6, not ours
    checkState("R4", 6, 0, 1);
    bankEn = 1'b0;
    @(negedge clk);
    check("R7", "bankActive when off", int'(bankActive), 1);
    busCycle(1, 0, BANK_ADDR, 16'h0020);
    checkState("R7", 6, 1, 0);
    bankEn = 1'b1;
    @(negedge clk);
    check("R7", "bankActive back on", int'(bankActive), 0);
  endtask

  task automatic testInit();
    busCycle(1, 0, BANK_ADDR, 16'o000040);         // flat mode
    check("R5", "flat active", int'(bankActive), 1);
    @(negedge clk);
    busInit = 1'b1;
    wrStb = 1'b1; wrAddr = BANK_ADDR; wrData = 16'h0060;
    @(negedge clk);
    busInit = 1'b0; wrStb = 1'b0; wrAddr = '0; wrData = '0;
    checkState("R6", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadAndMatch();
    testRestore();
    testNoStrap();
    testReads();
    testOtherAddr();
    testDisabled();
    testInit();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #50000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule